// File: doc/BRIEF.md
# Read-after-write hazard stall unit

This unit sits between the operand-fetch (DOF) stage and the execute (EX) stage of a four-stage in-order pipeline. In every cycle it compares the register read addresses of the instruction in DOF with the destination of the instruction in EX. An operand counts only when its source select actually picks the register file. If the EX instruction will write a register that DOF is about to read, the unit raises a stall. The stall freezes the program counter and instruction register, so the same instruction is presented again in the next cycle. At the same time the unit loads a neutralised copy of the DOF control word into the EX stage.

The unit owns the DOF-to-EX control register. The destination and write-enable fed back from that register drive its own comparison. The neutralised copy has its destination cleared as well as its write enables, so it cannot trip a second hazard, and one stall cycle is always enough. Register writes take the first half of a cycle and reads the second half, so only the one-stage EX-to-DOF distance is checked. Register 0 is never written and therefore never causes a hazard.

The unit has no state machine. Its only storage is the EX control register, and it never holds the stall for more than one cycle.

Top module: `hzd_stall_unit`

## Requirements
- R1: `haz_a` is 1 exactly when `dof_sel_pc_a` is 0 (A operand from the register file), `ex_rw` is 1, `ex_da` equals `dof_aa`, and `ex_da` is not 0.
- R2: `haz_b` is 1 exactly when `dof_sel_const_b` is 0 (B operand from the register file), `ex_rw` is 1, `ex_da` equals `dof_ba`, and `ex_da` is not 0.
- R3: An EX destination of register 0 never raises `haz_a` or `haz_b`, whatever `ex_rw` and the DOF addresses are.
- R4: `stall` is the OR of `haz_a` and `haz_b`. `pc_hold` and `ir_hold` both equal `stall` in the same cycle.
- R5: On a clock edge where `stall` is 1, the EX register loads `ex_da`=0, `ex_rw`=0, `ex_mw`=0 and `ex_bs`=0. It takes `ex_md`, `ex_ps` and `ex_fs` from the DOF word unchanged.
- R6: On a clock edge where `stall` is 0, every EX field takes the value of the corresponding DOF field.
- R7: A dependent pair gives exactly one stall cycle. While the same DOF instruction is held, `stall` is 0 in the cycle after the stall, and that instruction then enters EX unchanged on the next edge.
- R8: While `rst_n` is low, and after its release before any edge, all EX fields are 0, and `stall`, `pc_hold` and `ir_hold` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the EX control register |
| dof_aa | input | 5 | DOF A-operand register address |
| dof_ba | input | 5 | DOF B-operand register address |
| dof_sel_pc_a | input | 1 | 1: A operand is the PC, 0: register file |
| dof_sel_const_b | input | 1 | 1: B operand is the constant, 0: register file |
| dof_da | input | 5 | DOF destination register |
| dof_rw | input | 1 | DOF register write enable |
| dof_mw | input | 1 | DOF memory write enable |
| dof_md | input | 1 | DOF result select (memory or function unit) |
| dof_bs | input | 2 | DOF branch select |
| dof_ps | input | 1 | DOF branch polarity |
| dof_fs | input | 4 | DOF function select |
| haz_a | output | 1 | A-operand hazard |
| haz_b | output | 1 | B-operand hazard |
| stall | output | 1 | Stall request for this cycle |
| pc_hold | output | 1 | Hold all PC pipeline registers |
| ir_hold | output | 1 | Hold the instruction register |
| ex_da | output | 5 | EX destination register |
| ex_rw | output | 1 | EX register write enable |
| ex_mw | output | 1 | EX memory write enable |
| ex_md | output | 1 | EX result select |
| ex_bs | output | 2 | EX branch select |
| ex_ps | output | 1 | EX branch polarity |
| ex_fs | output | 4 | EX function select |

## Verification
The EX control register drives the `ex_*` ports directly. A wrong value loaded into it shows up at those ports one edge after the stall decision. It also shows up in the same cycle as a spurious or missing stall, because those fields feed the comparison. A bubble that keeps a nonzero destination or write enable would show as a second consecutive stall cycle. A comparator fault is visible on `haz_a`, `haz_b` and `stall` in the same cycle the DOF addresses are presented. The sweep covers every destination, including register 0, against matching and non-matching addresses under all source-select and write-enable combinations.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    parameter int REG_AW  = 5;
    parameter int FS_W    = 4;
    parameter int BS_W    = 2;
    parameter int NUM_OPS = 2;

    typedef struct packed {
        logic [REG_AW-1:0] da;
        logic              rw;
        logic              mw;
        logic              md;
        logic [BS_W-1:0]   bs;
        logic              ps;
        logic [FS_W-1:0]   fs;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '0;
endpackage

// File: rtl/hzd_operand_cmp.sv
module hzd_operand_cmp #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] rd_addr,
    input  logic          from_rf,
    input  logic [AW-1:0] ex_da,
    input  logic          ex_rw,
    output logic          hit
);
    logic dest_live;

    always_comb begin
        dest_live = ex_rw && (ex_da != '0);
        hit       = from_rf && dest_live && (ex_da == rd_addr);
    end
endmodule

// File: rtl/hzd_bubble_mux.sv
module hzd_bubble_mux
    import hzd_pkg::*;
(
    input  ctrl_t dof_word,
    input  logic  squash,
    output ctrl_t next_word
);
    always_comb begin
        next_word = dof_word;
        if (squash) begin
            next_word.da = '0;
            next_word.rw = 1'b0;
            next_word.mw = 1'b0;
            next_word.bs = '0;
        end
    end
endmodule

// File: rtl/hzd_ex_reg.sv
module hzd_ex_reg
    import hzd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t d_word,
    input  logic  squash,
    input  ctrl_t raw_word,
    output ctrl_t q_word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_word <= CTRL_IDLE;
        else        q_word <= d_word;
    end

    // R5
    bubble_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (q_word.da == '0) && !q_word.rw && !q_word.mw && (q_word.bs == '0)
                   && (q_word.fs == $past(raw_word.fs)) && (q_word.md == $past(raw_word.md)));

    // R6
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !squash |=> (q_word == $past(raw_word)));
endmodule

// File: rtl/hzd_stall_unit.sv
module hzd_stall_unit
    import hzd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] dof_aa,
    input  logic [REG_AW-1:0] dof_ba,
    input  logic              dof_sel_pc_a,
    input  logic              dof_sel_const_b,
    input  logic [REG_AW-1:0] dof_da,
    input  logic              dof_rw,
    input  logic              dof_mw,
    input  logic              dof_md,
    input  logic [BS_W-1:0]   dof_bs,
    input  logic              dof_ps,
    input  logic [FS_W-1:0]   dof_fs,
    output logic              haz_a,
    output logic              haz_b,
    output logic              stall,
    output logic              pc_hold,
    output logic              ir_hold,
    output logic [REG_AW-1:0] ex_da,
    output logic              ex_rw,
    output logic              ex_mw,
    output logic              ex_md,
    output logic [BS_W-1:0]   ex_bs,
    output logic              ex_ps,
    output logic [FS_W-1:0]   ex_fs
);
    ctrl_t dof_word;
    ctrl_t squashed_word;
    ctrl_t ex_word;

    logic [REG_AW-1:0] op_addr [NUM_OPS];
    logic              op_rf   [NUM_OPS];
    logic [NUM_OPS-1:0] op_hit;

    always_comb begin
        dof_word.da = dof_da;
        dof_word.rw = dof_rw;
        dof_word.mw = dof_mw;
        dof_word.md = dof_md;
        dof_word.bs = dof_bs;
        dof_word.ps = dof_ps;
        dof_word.fs = dof_fs;
        op_addr[0]  = dof_aa;
        op_addr[1]  = dof_ba;
        op_rf[0]    = !dof_sel_pc_a;
        op_rf[1]    = !dof_sel_const_b;
    end

    for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_op
        hzd_operand_cmp #(.AW(REG_AW)) u_cmp (
            .rd_addr (op_addr[gi]),
            .from_rf (op_rf[gi]),
            .ex_da   (ex_word.da),
            .ex_rw   (ex_word.rw),
            .hit     (op_hit[gi])
        );
    end

    always_comb begin
        haz_a   = op_hit[0];
        haz_b   = op_hit[1];
        stall   = |op_hit;
        pc_hold = stall;
        ir_hold = stall;
    end

    hzd_bubble_mux u_bubble (
        .dof_word  (dof_word),
        .squash    (stall),
        .next_word (squashed_word)
    );

    hzd_ex_reg u_ex (
        .clk      (clk),
        .rst_n    (rst_n),
        .d_word   (squashed_word),
        .squash   (stall),
        .raw_word (dof_word),
        .q_word   (ex_word)
    );

    always_comb begin
        ex_da = ex_word.da;
        ex_rw = ex_word.rw;
        ex_mw = ex_word.mw;
        ex_md = ex_word.md;
        ex_bs = ex_word.bs;
        ex_ps = ex_word.ps;
        ex_fs = ex_word.fs;
    end

    // R7
    single_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R3
    zero_dest_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (haz_a || haz_b) |-> (ex_da != '0) && ex_rw);

    // R1
    haz_a_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        haz_a |-> !dof_sel_pc_a && (dof_aa == ex_da));

    // R2
    haz_b_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        haz_b |-> !dof_sel_const_b && (dof_ba == ex_da));
endmodule

// File: tb/hzd_stall_unit_tb.sv
`timescale 1ns/100ps
module hzd_stall_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] dof_aa = '0, dof_ba = '0, dof_da = '0;
    logic       dof_sel_pc_a = 1'b1, dof_sel_const_b = 1'b1;
    logic       dof_rw = 1'b0, dof_mw = 1'b0, dof_md = 1'b0, dof_ps = 1'b0;
    logic [1:0] dof_bs = '0;
    logic [3:0] dof_fs = '0;
    logic       haz_a, haz_b, stall, pc_hold, ir_hold;
    logic [4:0] ex_da;
    logic       ex_rw, ex_mw, ex_md, ex_ps;
    logic [1:0] ex_bs;
    logic [3:0] ex_fs;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    hzd_stall_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .dof_aa(dof_aa), .dof_ba(dof_ba),
        .dof_sel_pc_a(dof_sel_pc_a), .dof_sel_const_b(dof_sel_const_b),
        .dof_da(dof_da), .dof_rw(dof_rw), .dof_mw(dof_mw), .dof_md(dof_md),
        .dof_bs(dof_bs), .dof_ps(dof_ps), .dof_fs(dof_fs),
        .haz_a(haz_a), .haz_b(haz_b), .stall(stall),
        .pc_hold(pc_hold), .ir_hold(ir_hold),
        .ex_da(ex_da), .ex_rw(ex_rw), .ex_mw(ex_mw), .ex_md(ex_md),
        .ex_bs(ex_bs), .ex_ps(ex_ps), .ex_fs(ex_fs)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pack_ex();
        return {ex_da, ex_rw, ex_mw, ex_md, ex_bs, ex_ps, ex_fs};
    endfunction

    function automatic int pack_word(input logic [4:0] da, input logic rw, input logic mw,
                                     input logic md, input logic [1:0] bs, input logic ps,
                                     input logic [3:0] fs);
        return {da, rw, mw, md, bs, ps, fs};
    endfunction

    task automatic drive(input logic [4:0] aa, input logic [4:0] ba, input logic spa,
                         input logic scb, input logic [4:0] da, input logic rw,
                         input logic mw, input logic md, input logic [1:0] bs,
                         input logic ps, input logic [3:0] fs);
        dof_aa = aa; dof_ba = ba; dof_sel_pc_a = spa; dof_sel_const_b = scb;
        dof_da = da; dof_rw = rw; dof_mw = mw; dof_md = md; dof_bs = bs;
        dof_ps = ps; dof_fs = fs;
    endtask

    initial begin
        #1;
        chk("R8 reset ex word", pack_ex(), 0);
        chk("R8 reset stall", int'(stall), 0);
        #10;
        chk("R8 reset held ex word", pack_ex(), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R8 after release ex word", pack_ex(), 0);
        chk("R8 after release holds", int'({stall, pc_hold, ir_hold}), 0);

        for (int d = 0; d < 32; d++) begin
            for (int sc = 0; sc < 32; sc++) begin
                logic       a_same, b_same, prw, ma, mb;
                logic [4:0] aa, ba;
                logic       ea, eb, es;
                int         cons;
                a_same = sc[0]; b_same = sc[1]; prw = sc[2]; ma = sc[3]; mb = sc[4];
                aa = a_same ? 5'(d) : 5'(d ^ 1);
                ba = b_same ? 5'(d) : 5'(d ^ 2);
                ea = !ma && prw && (d != 0) && a_same;
                eb = !mb && prw && (d != 0) && b_same;
                es = ea || eb;

                // producer: operands from PC and constant, so it never stalls
                @(negedge clk);
                drive(5'd0, 5'd0, 1'b1, 1'b1, 5'(d), prw, 1'b0, 1'b0, 2'b00, 1'b0, 4'h3);
                #1;
                chk("R6 producer no stall", int'(stall), 0);
                @(posedge clk); #1;
                chk("R6 producer in EX", pack_ex(),
                    pack_word(5'(d), prw, 1'b0, 1'b0, 2'b00, 1'b0, 4'h3));

                // consumer
                @(negedge clk);
                drive(aa, ba, ma, mb, 5'd9, 1'b1, 1'b1, 1'b1, 2'b01, 1'b1, 4'hA);
                cons = pack_word(5'd9, 1'b1, 1'b1, 1'b1, 2'b01, 1'b1, 4'hA);
                #1;
                if (d == 0) begin
                    chk("R3 zero dest A", int'(haz_a), 0);
                    chk("R3 zero dest B", int'(haz_b), 0);
                end else begin
                    chk("R1 haz_a", int'(haz_a), int'(ea));
                    chk("R2 haz_b", int'(haz_b), int'(eb));
                end
                chk("R4 stall", int'(stall), int'(es));
                chk("R4 holds", int'({pc_hold, ir_hold}), int'({es, es}));
                @(posedge clk); #1;
                if (es) begin
                    chk("R5 bubble word", pack_ex(),
                        pack_word(5'd0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 4'hA));
                    @(negedge clk); #1;
                    chk("R7 no second stall", int'(stall), 0);
                    @(posedge clk); #1;
                    chk("R7 replayed consumer in EX", pack_ex(), cons);
                end else begin
                    chk("R6 consumer in EX", pack_ex(), cons);
                end
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule